// File: doc/BRIEF.md
# Clock Output Mode and Gating Controller

This block turns a small set of configuration bytes and two board-level frequency-select pins into the control side of a system clock generator. It decides which frequency code goes to an external synthesizer and what each of thirteen clock outputs does: run from its source, sit actively low, float, or run from fixed divisions of the reference input while the synthesizer is bypassed for board test.

All clock sources (reference, synthesized CPU and PCI clocks, the 48 MHz clock) arrive as plain data inputs and are sampled on a fast internal clock, so every output is a registered, gated copy of its source. A configuration load strobe captures the three bytes into internal registers that reset to run with spread on, pin-selected frequency and all outputs enabled. Enable changes are applied only while the affected source is low, so no output ever sees a shortened high pulse.

Top module: `clkout_ctrl`

## Requirements
- R1: The mode field `cfg_ctrl[1:0]` selects 00 run without spread, 01 bypass test, 10 run with spread (reset default) and 11 all outputs floating; `spread_en` is 1 exactly when the captured mode is 10.
- R2: `cfg_ctrl[3]` picks the frequency source: at 0, `freq_code` is `{3'b000, fs_pin}`; at 1 it is `{1'b1, cfg_ctrl[7:4]}`. Reset selects the pins.
- R3: With the pin source, `cpu_rate`/`pci_rate` (tenths of MHz) are 1333/333 for pins 11, 1050/350 for 10, 1000/333 for 01 and 668/333 for 00; with the register source both are 0.
- R4: Output bit order in `clk_out`/`clk_oe` is 0-1 CPU, 2-8 PCI, 9 I/O interrupt-controller reference, 10 high-drive reference, 11 48 MHz, 12 24 MHz. Enables are `cfg_misc_en[1:0]` for CPU, `cfg_pci_en[6:0]` for PCI 0-6, `cfg_misc_en[2]` interrupt-controller reference, `[3]` 48 MHz, `[4]` 24 MHz; a 0 holds the output low, a 1 lets it run, and all reset to 1.
- R5: In bypass mode CPU outputs carry reference/2, PCI outputs reference/4, both reference outputs the reference, the 48 MHz output reference/2 and the 24 MHz output reference/4.
- R6: In floating mode every `clk_oe` bit is 0; in every other mode every bit is 1 (also after reset).
- R7: Bits `cfg_ctrl[2]`, `cfg_pci_en[7]` and `cfg_misc_en[7]` are reserved and change nothing.
- R8: The high-drive reference output is enabled only when both `cfg_misc_en[5]` and `cfg_misc_en[6]` are 1.
- R9: An enable change reaches an output only at a clock edge where its source is low: a high output is never cut short and a disabled output does not start mid-high.
- R10: In run modes each output follows its source input two clock edges after the input changes; the 24 MHz output is the 48 MHz input divided by 2.
- R11: `freq_code` is registered and changes only after a configuration load or a pin change, one edge after the pins are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock level |
| cpu_in | input | 1 | Synthesized CPU clock level |
| pci_in | input | 1 | Synthesized PCI clock level |
| f48_in | input | 1 | 48 MHz clock level |
| fs_pin | input | 2 | Frequency-select pins |
| cfg_load | input | 1 | Capture the three configuration bytes |
| cfg_ctrl | input | 8 | Mode, frequency source and register frequency select |
| cfg_pci_en | input | 8 | PCI output enables |
| cfg_misc_en | input | 8 | CPU, reference and USB clock enables |
| clk_out | output | 13 | Gated clock outputs |
| clk_oe | output | 13 | Output drive enables (0 = high impedance) |
| freq_code | output | 5 | Code to the synthesizer |
| spread_en | output | 1 | Spread modulation request |
| cpu_rate | output | 12 | CPU rate for pin source, tenths of MHz |
| pci_rate | output | 12 | PCI rate for pin source, tenths of MHz |

## Verification
A source input change is sampled at the next edge and reaches `clk_out` one edge later; a load updates `freq_code`, `spread_en` and `clk_oe` one edge after the capture edge, and a pin change shows on `freq_code` two edges after the change. The latency checks sample at the negative edge exactly one and two edges after a change, while the table and directed checks wait at least four cycles so the result is settled. Bypass division and the 24 MHz divider are checked by counting rising output edges over a fixed number of source pulses, which does not depend on divider phase.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    localparam int N_CPU    = 2;
    localparam int N_PCI    = 7;
    localparam int IDX_CPU0 = 0;
    localparam int IDX_PCI0 = IDX_CPU0 + N_CPU;
    localparam int IDX_APIC = IDX_PCI0 + N_PCI;
    localparam int IDX_REF  = IDX_APIC + 1;
    localparam int IDX_48   = IDX_REF + 1;
    localparam int IDX_24   = IDX_48 + 1;
    localparam int N_OUT    = IDX_24 + 1;
    localparam int SEL_W    = 4;
    localparam int CODE_W   = SEL_W + 1;
    localparam int RATE_W   = 12;
    localparam int DIV_W    = 2;

    typedef enum logic [1:0] {
        MODE_SSC_OFF = 2'b00,
        MODE_BYPASS  = 2'b01,
        MODE_SSC_ON  = 2'b10,
        MODE_HIZ     = 2'b11
    } run_mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             use_reg;
        run_mode_e        mode;
    } ctrl_t;

    typedef struct packed {
        logic [RATE_W-1:0] cpu;
        logic [RATE_W-1:0] pci;
    } rate_t;

    typedef struct packed {
        logic refc;
        logic cpu;
        logic pci;
        logic f48;
        logic ref_d2;
        logic ref_d4;
        logic f48_d2;
    } src_t;

    localparam ctrl_t CTRL_RESET = '{sel: '0, use_reg: 1'b0, mode: MODE_SSC_ON};

    function automatic ctrl_t unpack_ctrl(input logic [7:0] b);
        ctrl_t c;
        c.sel     = b[7:4];
        c.use_reg = b[3];
        c.mode    = run_mode_e'(b[1:0]);
        return c;
    endfunction

    function automatic logic [N_OUT-1:0] map_enables(input logic [7:0] pci_b,
                                                    input logic [7:0] misc_b);
        logic [N_OUT-1:0] e;
        e[IDX_CPU0 +: N_CPU] = misc_b[N_CPU-1:0];
        e[IDX_PCI0 +: N_PCI] = pci_b[N_PCI-1:0];
        e[IDX_APIC]          = misc_b[2];
        e[IDX_REF]           = misc_b[5] & misc_b[6];
        e[IDX_48]            = misc_b[3];
        e[IDX_24]            = misc_b[4];
        return e;
    endfunction

    function automatic rate_t pin_rate(input logic [1:0] fs);
        rate_t r;
        case (fs)
            2'b11:   r = '{cpu: 12'd1333, pci: 12'd333};
            2'b10:   r = '{cpu: 12'd1050, pci: 12'd350};
            2'b01:   r = '{cpu: 12'd1000, pci: 12'd333};
            default: r = '{cpu: 12'd668,  pci: 12'd333};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkgate_sampler.sv
module clkgate_sampler
    import clkgate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic cpu_in,
    input  logic pci_in,
    input  logic f48_in,
    output src_t src
);

    logic             ref_s, cpu_s, pci_s, f48_s;
    logic             ref_prev, f48_prev;
    logic [DIV_W-1:0] div_cnt;
    logic             f48_half;
    logic             ref_rise, f48_rise;

    assign ref_rise = ref_s & ~ref_prev;
    assign f48_rise = f48_s & ~f48_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_s    <= 1'b0;
            cpu_s    <= 1'b0;
            pci_s    <= 1'b0;
            f48_s    <= 1'b0;
            ref_prev <= 1'b0;
            f48_prev <= 1'b0;
            div_cnt  <= '0;
            f48_half <= 1'b0;
        end else begin
            ref_s    <= ref_in;
            cpu_s    <= cpu_in;
            pci_s    <= pci_in;
            f48_s    <= f48_in;
            ref_prev <= ref_s;
            f48_prev <= f48_s;
            if (ref_rise) div_cnt  <= div_cnt + 1'b1;
            if (f48_rise) f48_half <= ~f48_half;
        end
    end

    assign src = '{refc: ref_s, cpu: cpu_s, pci: pci_s, f48: f48_s,
                   ref_d2: div_cnt[0], ref_d4: div_cnt[DIV_W-1], f48_d2: f48_half};

    // R5: the bypass divider advances only on a reference rising edge
    a_r5_div_on_ref_edge: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_cnt) |-> $past(ref_rise));

endmodule

// File: rtl/clkgate_cfg.sv
module clkgate_cfg
    import clkgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [7:0]        ctrl_byte,
    input  logic [7:0]        pci_byte,
    input  logic [7:0]        misc_byte,
    input  logic [1:0]        fs_pin,
    output run_mode_e         mode,
    output logic [N_OUT-1:0]  en,
    output logic [CODE_W-1:0] freq_code,
    output logic              spread_en,
    output rate_t             rate
);

    ctrl_t      ctrl_q;
    logic [1:0] fs_s;
    logic       unused_rsvd;

    assign unused_rsvd = ^{ctrl_byte[2], pci_byte[7], misc_byte[7]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RESET;
            en        <= '1;
            fs_s      <= '0;
            freq_code <= '0;
            spread_en <= 1'b1;
            rate      <= '0;
        end else begin
            fs_s <= fs_pin;
            if (load) begin
                ctrl_q <= unpack_ctrl(ctrl_byte);
                en     <= map_enables(pci_byte, misc_byte);
            end
            freq_code <= ctrl_q.use_reg ? {1'b1, ctrl_q.sel} : {3'b000, fs_s};
            spread_en <= (ctrl_q.mode == MODE_SSC_ON);
            rate      <= ctrl_q.use_reg ? '0 : pin_rate(fs_s);
        end
    end

    assign mode = ctrl_q.mode;

    // R11: the code moves only when the captured control or the pins moved
    a_r11_code_has_cause: assert property (@(posedge clk) disable iff (rst)
        !$stable(freq_code) |->
            (($past(ctrl_q) != $past(ctrl_q, 2)) || ($past(fs_s) != $past(fs_s, 2))));

endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic en,
    output logic out
);

    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b1;
            out    <= 1'b0;
        end else begin
            if (!src) gate_q <= en;
            out <= src & gate_q;
        end
    end

    // R9: the gate moves only at an edge where the source is low
    a_r9_gate_moves_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(gate_q) |-> !$past(src));

    // R4: a closed gate holds the output low
    a_r4_closed_is_low: assert property (@(posedge clk) disable iff (rst)
        !gate_q |=> !out);

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
    import clkgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              cpu_in,
    input  logic              pci_in,
    input  logic              f48_in,
    input  logic [1:0]        fs_pin,
    input  logic              cfg_load,
    input  logic [7:0]        cfg_ctrl,
    input  logic [7:0]        cfg_pci_en,
    input  logic [7:0]        cfg_misc_en,
    output logic [N_OUT-1:0]  clk_out,
    output logic [N_OUT-1:0]  clk_oe,
    output logic [CODE_W-1:0] freq_code,
    output logic              spread_en,
    output logic [RATE_W-1:0] cpu_rate,
    output logic [RATE_W-1:0] pci_rate
);

    src_t             src;
    run_mode_e        mode;
    logic [N_OUT-1:0] en_q;
    logic [N_OUT-1:0] src_sel;
    rate_t            rate;
    logic             bypass;

    clkgate_sampler u_sampler (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_in),
        .cpu_in (cpu_in),
        .pci_in (pci_in),
        .f48_in (f48_in),
        .src    (src)
    );

    clkgate_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (cfg_load),
        .ctrl_byte (cfg_ctrl),
        .pci_byte  (cfg_pci_en),
        .misc_byte (cfg_misc_en),
        .fs_pin    (fs_pin),
        .mode      (mode),
        .en        (en_q),
        .freq_code (freq_code),
        .spread_en (spread_en),
        .rate      (rate)
    );

    assign cpu_rate = rate.cpu;
    assign pci_rate = rate.pci;
    assign bypass   = (mode == MODE_BYPASS);

    always_comb begin
        for (int i = 0; i < N_CPU; i++)
            src_sel[IDX_CPU0 + i] = bypass ? src.ref_d2 : src.cpu;
        for (int i = 0; i < N_PCI; i++)
            src_sel[IDX_PCI0 + i] = bypass ? src.ref_d4 : src.pci;
        src_sel[IDX_APIC] = src.refc;
        src_sel[IDX_REF]  = src.refc;
        src_sel[IDX_48]   = bypass ? src.ref_d2 : src.f48;
        src_sel[IDX_24]   = bypass ? src.ref_d4 : src.f48_d2;
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        clkgate_cell u_cell (
            .clk (clk),
            .rst (rst),
            .src (src_sel[g]),
            .en  (en_q[g]),
            .out (clk_out[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) clk_oe <= '1;
        else     clk_oe <= {N_OUT{mode != MODE_HIZ}};
    end

    // R6: floating mode releases every output on the next edge
    a_r6_float_all: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HIZ) |=> (clk_oe == '0));

    // R1: spread request only follows the spread-on mode
    a_r1_spread_only_mode10: assert property (@(posedge clk) disable iff (rst)
        spread_en |-> ($past(mode) == MODE_SSC_ON));

endmodule

// File: tb/clkout_ctrl_test.sv
module clkout_ctrl_test;

    localparam int NO = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0, cpu_in = 1'b0, pci_in = 1'b0, f48_in = 1'b0;
    logic [1:0] fs_pin = 2'b11;
    logic cfg_load = 1'b0;
    logic [7:0] cfg_ctrl = 8'h02, cfg_pci_en = 8'hFF, cfg_misc_en = 8'hFF;
    logic [NO-1:0] clk_out, clk_oe;
    logic [4:0] freq_code;
    logic spread_en;
    logic [11:0] cpu_rate, pci_rate;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    clkout_ctrl uut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .cpu_in(cpu_in), .pci_in(pci_in),
        .f48_in(f48_in), .fs_pin(fs_pin), .cfg_load(cfg_load), .cfg_ctrl(cfg_ctrl),
        .cfg_pci_en(cfg_pci_en), .cfg_misc_en(cfg_misc_en), .clk_out(clk_out),
        .clk_oe(clk_oe), .freq_code(freq_code), .spread_en(spread_en),
        .cpu_rate(cpu_rate), .pci_rate(pci_rate)
    );

    // rising-edge counters on every output
    int rises [NO];
    logic [NO-1:0] prev_out = '0;
    bit clr_req = 1'b0;
    always @(negedge clk) begin
        for (int i = 0; i < NO; i++) begin
            if (clr_req) rises[i] = 0;
            else if (clk_out[i] && !prev_out[i]) rises[i] = rises[i] + 1;
        end
        prev_out = clk_out;
    end

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  pen;
        logic [7:0]  men;
        logic [1:0]  fs;
        logic [4:0]  code;
        logic        spread;
        logic        oe;
        logic [11:0] crate;
        logic [11:0] prate;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{8'h02, 8'hFF, 8'hFF, 2'b11, 5'b00011, 1'b1, 1'b1, 12'd1333, 12'd333},
        '{8'h00, 8'hFF, 8'hFF, 2'b10, 5'b00010, 1'b0, 1'b1, 12'd1050, 12'd350},
        '{8'h00, 8'hFF, 8'hFE, 2'b01, 5'b00001, 1'b0, 1'b1, 12'd1000, 12'd333},
        '{8'h00, 8'h55, 8'hFF, 2'b00, 5'b00000, 1'b0, 1'b1, 12'd668,  12'd333},
        '{8'hA8, 8'hFF, 8'hFF, 2'b01, 5'b11010, 1'b0, 1'b1, 12'd0,    12'd0},
        '{8'h5A, 8'hAA, 8'hE7, 2'b10, 5'b10101, 1'b1, 1'b1, 12'd0,    12'd0},
        '{8'h03, 8'hFF, 8'hFF, 2'b01, 5'b00001, 1'b0, 1'b0, 12'd1000, 12'd333},
        '{8'h06, 8'hFF, 8'hDF, 2'b11, 5'b00011, 1'b1, 1'b1, 12'd1333, 12'd333}
    };

    // expected outputs with every source held high (bit 12 depends on history)
    function automatic logic [NO-1:0] exp_out(input logic [7:0] p, input logic [7:0] m);
        logic [NO-1:0] e;
        e[1:0]  = m[1:0];
        e[8:2]  = p[6:0];
        e[9]    = m[2];
        e[10]   = m[5] & m[6];
        e[11]   = m[3];
        e[12]   = m[4];
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] c, input logic [7:0] p, input logic [7:0] m);
        @(negedge clk);
        cfg_ctrl = c; cfg_pci_en = p; cfg_misc_en = m; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic set_srcs(input logic v);
        cpu_in = v; pci_in = v; ref_in = v; f48_in = v;
    endtask

    task automatic clear_counts();
        @(posedge clk); clr_req = 1'b1;
        @(posedge clk); clr_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_ref(input int n);
        for (int k = 0; k < n; k++) begin
            ref_in = 1'b1; wait_n(4);
            ref_in = 1'b0; wait_n(4);
        end
    endtask

    task automatic pulse_f48(input int n);
        for (int k = 0; k < n; k++) begin
            f48_in = 1'b1; wait_n(4);
            f48_in = 1'b0; wait_n(4);
        end
    endtask

    initial begin
        wait_n(5);
        rst = 1'b0;
        wait_n(4);
        // reset state
        check(clk_oe == '1, "R6 reset oe", clk_oe, 13'h1FFF);
        check(spread_en == 1'b1, "R1 reset spread", spread_en, 1);
        check(freq_code == 5'b00011, "R2 reset pin source", freq_code, 5'b00011);
        check(cpu_rate == 12'd1333, "R3 reset cpu rate", cpu_rate, 1333);
        check(clk_out == '0, "R4 reset outputs", clk_out, 0);

        // table walk
        for (int v = 0; v < 8; v++) begin
            set_srcs(1'b0);
            fs_pin = VEC[v].fs;
            load(VEC[v].ctrl, VEC[v].pen, VEC[v].men);
            wait_n(4);
            set_srcs(1'b1);
            wait_n(4);
            check(freq_code == VEC[v].code, "R2 R7 code", freq_code, VEC[v].code);
            check(spread_en == VEC[v].spread, "R1 spread", spread_en, VEC[v].spread);
            check(cpu_rate == VEC[v].crate, "R3 cpu rate", cpu_rate, VEC[v].crate);
            check(pci_rate == VEC[v].prate, "R3 pci rate", pci_rate, VEC[v].prate);
            check(clk_oe == {NO{VEC[v].oe}}, "R6 oe", clk_oe, {NO{VEC[v].oe}});
            if (VEC[v].oe)
                check((clk_out & 13'h0FFF) == (exp_out(VEC[v].pen, VEC[v].men) & 13'h0FFF),
                      "R4 R7 R8 outputs", clk_out, exp_out(VEC[v].pen, VEC[v].men));
        end

        // R5: bypass divisions
        set_srcs(1'b0);
        load(8'h01, 8'hFF, 8'hFF);
        wait_n(6);
        check(spread_en == 1'b0, "R1 bypass spread", spread_en, 0);
        clear_counts();
        pulse_ref(8);
        wait_n(8);
        check(rises[0] == 4, "R5 cpu ref/2", rises[0], 4);
        check(rises[1] == 4, "R5 cpu1 ref/2", rises[1], 4);
        check(rises[2] == 2, "R5 pci ref/4", rises[2], 2);
        check(rises[9] == 8, "R5 apic ref", rises[9], 8);
        check(rises[10] == 8, "R5 ref2x ref", rises[10], 8);
        check(rises[11] == 4, "R5 48 ref/2", rises[11], 4);
        check(rises[12] == 2, "R5 24 ref/4", rises[12], 2);

        // R10: 24 output from the 48 input in run mode
        load(8'h02, 8'hFF, 8'hFF);
        wait_n(6);
        clear_counts();
        pulse_f48(4);
        wait_n(8);
        check(rises[11] == 4, "R10 48 follows", rises[11], 4);
        check(rises[12] == 2, "R10 24 halves", rises[12], 2);

        // R9: no runt when disabling / enabling
        cpu_in = 1'b1; wait_n(4);
        check(clk_out[0] == 1'b1, "R4 cpu0 runs", clk_out[0], 1);
        load(8'h02, 8'hFF, 8'hFE);
        wait_n(4);
        check(clk_out[0] == 1'b1, "R9 high not cut", clk_out[0], 1);
        cpu_in = 1'b0; wait_n(4);
        cpu_in = 1'b1; wait_n(4);
        check(clk_out[0] == 1'b0, "R4 disabled low", clk_out[0], 0);
        check(clk_out[1] == 1'b1, "R4 cpu1 unaffected", clk_out[1], 1);
        load(8'h02, 8'hFF, 8'hFF);
        wait_n(4);
        check(clk_out[0] == 1'b0, "R9 no mid-high start", clk_out[0], 0);
        cpu_in = 1'b0; wait_n(4);
        cpu_in = 1'b1; wait_n(4);
        check(clk_out[0] == 1'b1, "R9 resumes on next high", clk_out[0], 1);

        // R10: exact latency on a PCI output
        set_srcs(1'b0); wait_n(4);
        pci_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check(clk_out[2] == 1'b0, "R10 one edge", clk_out[2], 0);
        @(posedge clk); @(negedge clk);
        check(clk_out[2] == 1'b1, "R10 two edges", clk_out[2], 1);

        // R11: pin change latency and register-source immunity
        fs_pin = 2'b01;
        @(posedge clk); @(negedge clk);
        check(freq_code == 5'b00011, "R11 code holds one edge", freq_code, 5'b00011);
        @(posedge clk); @(negedge clk);
        check(freq_code == 5'b00001, "R11 code after two edges", freq_code, 5'b00001);
        load(8'hA8, 8'hFF, 8'hFF);
        wait_n(4);
        fs_pin = 2'b10;
        wait_n(4);
        check(freq_code == 5'b11010, "R11 R2 pins ignored", freq_code, 5'b11010);
        check(cpu_rate == 12'd0, "R3 register source rate", cpu_rate, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule